// File: doc/BRIEF.md
# DMA Burst Segmentation Planner

This block takes one DMA descriptor at a time (a starting byte address on a word boundary, a transfer length counted in 32-bit words, and a byte-swap flag). It turns the descriptor into a sequence of burst commands for a downstream bus engine. Each command carries a byte address, a burst length in words and the swap flag. No burst is longer than `MAX_BURST` words (8 by default), which is the longest sustained transfer the attached buses support. No burst crosses a `MAX_BURST`-word aligned boundary.

A transfer that starts off a boundary begins with a short head burst that just reaches the boundary. Full-size bursts follow while enough words remain, and a short tail burst carries what is left. The bus engine gives up the bus after each burst, so every burst is a separate command. The engine takes a command through a valid/ready handshake and reports completion with a one-cycle `bst_done` pulse. Only then does the planner offer the next command. After the last burst of a descriptor completes, the planner pulses `done` and accepts a new descriptor.

Top module: `dma_burst_planner`

## Requirements
- R1: Every burst command has a length from 1 to MAX_BURST (8) words.
- R2: When the word address (byte address bit 2 upward) modulo 8 is k, with k not 0, the first burst is min(8 - k, length) words long. No burst crosses an 8-word boundary.
- R3: While the address is on an 8-word boundary and at least 8 words remain, each burst is exactly 8 words long.
- R4: The final burst carries the remaining words, and `bst_last` is 1 on that burst and 0 on every other burst.
- R5: The first burst address is the descriptor address. Each following burst address equals the previous one plus 4 times the previous length, and the lengths add up to the descriptor length.
- R6: While `bst_valid` is 1 and `bst_ready` is 0, address, length, swap and last hold steady. After a burst is taken, no new burst is offered until a `bst_done` pulse arrives.
- R7: `done` is 1 for exactly the one cycle after the clock edge that samples `bst_done` for the last burst.
- R8: A descriptor of length 0 produces no burst, and `done` is 1 in the cycle after the descriptor is accepted.
- R9: `desc_ready` is 1 only while no descriptor is in progress. Descriptor inputs and `bst_done` pulses presented while the block is busy, other than the one awaited, do not change the burst sequence.
- R10: Every burst of a descriptor carries that descriptor's swap flag.
- R11: After reset, `desc_ready` is 1 and both `bst_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Planner idle, descriptor taken when valid |
| desc_addr | input | ADDR_W | Starting byte address; bits 1:0 are ignored |
| desc_len | input | LEN_W | Transfer length in 32-bit words |
| desc_swap | input | 1 | Byte-swap request |
| bst_valid | output | 1 | Burst command offered |
| bst_ready | input | 1 | Bus engine takes the burst command |
| bst_addr | output | ADDR_W | Burst byte address |
| bst_len | output | $clog2(MAX_BURST)+1 | Burst length in words |
| bst_swap | output | 1 | Byte-swap flag of the burst |
| bst_last | output | 1 | Final burst of the descriptor |
| bst_done | input | 1 | Bus engine finished the taken burst |
| done | output | 1 | One-cycle pulse when the descriptor completes |

## Verification
Directed descriptors come first. One starts aligned with 16 words, separating body bursts from the tail. One starts one word past a boundary with 16 words, giving a 7-8-1 split. One starts five words in with only 2 words, so the head burst is also the last. One is an aligned 6-word transfer, where the tail alone is the whole transfer. Other cases are a misaligned exact 8, an aligned exact 8, a single word at offset 7, and a zero-length descriptor. These separate the head, body and tail rules, plus the empty case. After them come random descriptors with random ready stalls and random completion pulses. Junk descriptors are held on the input while the block is busy. These expose any field that moves during a stall, any ignored input that leaks in, and `done` arriving a cycle off.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } dmab_state_e;

endpackage

// File: rtl/dmab_size_calc.sv
module dmab_size_calc #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 8,
    localparam int OFF_W    = $clog2(MAX_BURST),
    localparam int BLEN_W   = OFF_W + 1
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [BLEN_W-1:0] burst_len,
    output logic              burst_last
);

    logic [OFF_W-1:0]  word_off;
    logic [BLEN_W-1:0] room;

    // Words left before the next MAX_BURST-word boundary
    always_comb begin
        word_off = cur_addr[OFF_W+1:2];
        room     = BLEN_W'(MAX_BURST) - {1'b0, word_off};
        if (remain <= LEN_W'(room)) begin
            burst_len  = remain[BLEN_W-1:0];
            burst_last = 1'b1;
        end else begin
            burst_len  = room;
            burst_last = 1'b0;
        end
    end

endmodule

// File: rtl/dmab_ctrl.sv
module dmab_ctrl
    import dmab_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 8,
    localparam int OFF_W    = $clog2(MAX_BURST),
    localparam int BLEN_W   = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_swap,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic              bst_swap,
    input  logic              bst_done,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_remain,
    input  logic [BLEN_W-1:0] burst_len,
    input  logic              burst_last
);

    typedef struct packed {
        dmab_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic              swap;
        logic              last;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (desc_valid) begin
                    r_d.addr = {desc_addr[ADDR_W-1:2], 2'b00};
                    r_d.rem  = desc_len;
                    r_d.swap = desc_swap;
                    if (desc_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (bst_ready) begin
                    r_d.addr  = r_q.addr + (ADDR_W'(burst_len) << 2);
                    r_d.rem   = r_q.rem - LEN_W'(burst_len);
                    r_d.last  = burst_last;
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (bst_done) begin
                    if (r_q.last) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, rem: '0, swap: 1'b0, last: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign desc_ready = (r_q.state == ST_IDLE);
    assign bst_valid  = (r_q.state == ST_ISSUE);
    assign bst_addr   = r_q.addr;
    assign bst_swap   = r_q.swap;
    assign done       = r_q.done;
    assign cur_addr   = r_q.addr;
    assign cur_remain = r_q.rem;

    // R1: length in range
    a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (burst_len != '0) && (burst_len <= BLEN_W'(MAX_BURST)));

    // R2: a burst never crosses a MAX_BURST boundary
    a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> ((32'(r_q.addr[OFF_W+1:2]) + 32'(burst_len)) <= 32'(MAX_BURST)));

    // R6: command held while stalled
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> bst_valid && $stable(bst_addr)
                                      && $stable(burst_len) && $stable(bst_swap));

    // R4: taking the last burst drains the count
    a_r4_last_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready && burst_last) |=> (cur_remain == '0));

    // R8: empty descriptor completes at once
    a_r8_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && desc_len == '0) |=> done && !bst_valid);

endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 8,
    localparam int OFF_W    = $clog2(MAX_BURST),
    localparam int BLEN_W   = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_swap,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [BLEN_W-1:0] bst_len,
    output logic              bst_swap,
    output logic              bst_last,
    input  logic              bst_done,
    output logic              done
);

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_remain;
    logic [BLEN_W-1:0] burst_len;
    logic              burst_last;

    dmab_size_calc #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .MAX_BURST (MAX_BURST)
    ) u_size (
        .cur_addr   (cur_addr),
        .remain     (cur_remain),
        .burst_len  (burst_len),
        .burst_last (burst_last)
    );

    dmab_ctrl #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .MAX_BURST (MAX_BURST)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .desc_addr  (desc_addr),
        .desc_len   (desc_len),
        .desc_swap  (desc_swap),
        .bst_valid  (bst_valid),
        .bst_ready  (bst_ready),
        .bst_addr   (bst_addr),
        .bst_swap   (bst_swap),
        .bst_done   (bst_done),
        .done       (done),
        .cur_addr   (cur_addr),
        .cur_remain (cur_remain),
        .burst_len  (burst_len),
        .burst_last (burst_last)
    );

    assign bst_len  = burst_len;
    assign bst_last = burst_last;

    // R10: swap flag held for a whole descriptor
    a_r10_swap_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_ready && !done) |=> $stable(bst_swap));

endmodule

// File: tb/tb_dma_burst_planner.sv
module tb_dma_burst_planner;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int MB     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic              desc_swap = 1'b0;
    logic              bst_valid;
    logic              bst_ready = 1'b0;
    logic [ADDR_W-1:0] bst_addr;
    logic [3:0]        bst_len;
    logic              bst_swap;
    logic              bst_last;
    logic              bst_done = 1'b0;
    logic              done;

    always #4 clk = ~clk;

    dma_burst_planner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MB)) dut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
        .desc_len(desc_len), .desc_swap(desc_swap),
        .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
        .bst_len(bst_len), .bst_swap(bst_swap), .bst_last(bst_last),
        .bst_done(bst_done), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        logic [31:0] addr;
        int          len;
        bit          last;
    } beat_t;

    beat_t exp_q[$];
    int    m_state = 0;   // 0 idle, 1 offering, 2 awaiting completion
    bit    m_swap = 1'b0;
    bit    m_done = 1'b0;
    bit    m_zero = 1'b0;
    bit    m_first = 1'b0;
    bit    m_misal = 1'b0;
    bit    m_cur_last = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_done = 1'b0; exp_q.delete();
        end else begin
            m_done = 1'b0;
            case (m_state)
                0: if (desc_valid) begin
                    m_swap = desc_swap;
                    if (desc_len == 0) begin
                        m_done = 1'b1; m_zero = 1'b1;
                    end else begin
                        logic [31:0] a;
                        int r;
                        a = {desc_addr[31:2], 2'b00};
                        r = int'(desc_len);
                        m_misal = (a[4:2] != 0);
                        while (r > 0) begin
                            beat_t b;
                            int room;
                            room = MB - int'(a[4:2]);
                            b.addr = a;
                            b.len  = (r < room) ? r : room;
                            b.last = (b.len == r);
                            exp_q.push_back(b);
                            a = a + 32'(4 * b.len);
                            r = r - b.len;
                        end
                        m_first = 1'b1;
                        m_state = 1;
                    end
                end
                1: if (bst_ready) begin
                    m_cur_last = exp_q[0].last;
                    void'(exp_q.pop_front());
                    m_first = 1'b0;
                    m_state = 2;
                end
                2: if (bst_done) begin
                    if (m_cur_last) begin
                        m_done = 1'b1; m_zero = 1'b0; m_state = 0;
                    end else begin
                        m_state = 1;
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    // ---------------- comparison on every clock ----------------
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk(desc_ready == 1'b1, "R11 desc_ready", desc_ready, 1);
                chk(bst_valid == 1'b0, "R11 bst_valid", bst_valid, 0);
                chk(done == 1'b0, "R11 done", done, 0);
            end else begin
                chk(desc_ready == (m_state == 0), "R9 desc_ready", desc_ready, m_state == 0);
                chk(bst_valid == (m_state == 1), "R6 bst_valid", bst_valid, m_state == 1);
                chk(done == m_done, m_zero ? "R8 done" : "R7 done", done, m_done);
                if (m_state == 1 && bst_valid && exp_q.size() > 0) begin
                    chk(bst_len >= 1 && bst_len <= MB, "R1 len range", bst_len, MB);
                    chk(bst_addr == exp_q[0].addr, "R5 addr", bst_addr, exp_q[0].addr);
                    chk(int'(bst_len) == exp_q[0].len,
                        (m_first && m_misal) ? "R2 head len" : (exp_q[0].last ? "R4 tail len" : "R3 body len"),
                        bst_len, exp_q[0].len);
                    chk(bst_last == exp_q[0].last, "R4 last flag", bst_last, exp_q[0].last);
                    chk(bst_swap == m_swap, "R10 swap", bst_swap, m_swap);
                end
            end
        end
    end

    // ---------------- downstream engine: random stalls and completions ----------------
    always @(negedge clk) begin
        bst_ready = ($urandom % 4) != 0;
        bst_done  = ($urandom % 3) == 0;
    end

    // ---------------- descriptor driver ----------------
    task automatic send_desc(input logic [31:0] a, input int n, input bit sw);
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_valid = 1'b1; desc_addr = a; desc_len = LEN_W'(n); desc_swap = sw;
        @(negedge clk);
        // R9: junk held on the input while busy must be ignored
        while (!desc_ready) begin
            desc_valid = 1'b1;
            desc_addr  = $urandom;
            desc_len   = LEN_W'($urandom % 5);
            desc_swap  = ~sw;
            @(negedge clk);
        end
        desc_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send_desc(32'h0000_4000, 16, 1'b0);   // R3: aligned, two body bursts
        send_desc(32'h0000_4A04, 16, 1'b1);   // R2: 7, 8, 1
        send_desc(32'h0000_4F00, 6, 1'b1);    // R4: tail only
        send_desc(32'h0000_4014, 2, 1'b0);    // R2, R4: head is last
        send_desc(32'h0000_100C, 8, 1'b0);    // R2: 5 then 3
        send_desc(32'h0000_2000, 8, 1'b1);    // R3: exact 8
        send_desc(32'h0000_301C, 1, 1'b0);    // R1: single word at offset 7
        send_desc(32'h0000_5000, 0, 1'b1);    // R8: empty
        send_desc(32'h0000_5004, 0, 1'b0);    // R8: empty back to back
        for (int i = 0; i < 300; i++) begin
            send_desc($urandom, int'($urandom % 41), 1'($urandom));
        end
        repeat (20) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule